// File: doc/BRIEF.md
# Floating-Point Rounding-Mode and Exception-Flag Controller

This block works next to a floating-point execution unit. When an operation is issued, it turns the instruction's 3-bit rounding field into the rounding mode the datapath should use. The field comes from instruction bits 14 to 12. A field value of 7 means "dynamic", and the mode is then taken from a 3-bit rounding-mode register. A reserved encoding in the field, or in that register, rejects the operation at issue with a one-cycle illegal-instruction strobe. A rejected operation never writes back and never touches the exception flags.

Once an operation is accepted, the block holds its resolved mode steady until the datapath reports completion. On the completion cycle it raises a one-cycle writeback enable and ORs the datapath's exception flags into a sticky 5-bit flag register. Both registers also have a register-write port, and that port has priority over a flag merge in the same cycle.

A small two-state sequencer controls the block. The two states are IDLE (waiting for an issue) and BUSY (an accepted operation is in flight). IDLE goes to BUSY on a legal issue. A reserved issue keeps the sequencer in IDLE and raises the fault strobe. BUSY goes back to IDLE on the datapath done pulse, which raises the writeback enable and merges the flags. Every other case keeps the current state.

Top module: `fprm_flag_ctrl`

## Requirements
- R1: After reset the rounding-mode register and the flag register both read 0, the sequencer is IDLE, and the fault strobe and writeback enable are low.
- R2: In IDLE, an issue with field 0, 1, 2, 3 or 4 drives that same code on `rm_o` in the issue cycle. The codes mean nearest-even, toward-zero, down, up and nearest-ties-to-max-magnitude, and all five are legal. The code stays on `rm_o` every cycle until done.
- R3: An issue with field 7 resolves to the value of the rounding-mode register at issue. That value is held for the whole operation: a later write to the register does not change `rm_o` until done.
- R4: An issue with field 5 or 6 raises `fault_o` for exactly the issue cycle. It does not enter BUSY and never raises `wb_en_o`.
- R5: An issue with field 7 while the rounding-mode register holds 5, 6 or 7 raises `fault_o` for the issue cycle, just as in R4.
- R6: In BUSY, `dp_done_i` raises `wb_en_o` in that same cycle only. At the next edge, `dp_flags_i` is ORed into the flag register. Flag bits: inexact is bit 0, underflow bit 1, overflow bit 2, divide-by-zero bit 3, invalid bit 4.
- R7: Flags are sticky. A merge never clears a bit, so a completion that reports no flags leaves the register unchanged.
- R8: A faulted operation leaves the flag register unchanged.
- R9: A flag-register write in the same cycle as a merge wins: the register takes the written value only.
- R10: An issue that arrives while BUSY is ignored. It raises no fault, even with a reserved field, and `rm_o` keeps the in-flight mode.
- R11: `dp_done_i` in IDLE raises no writeback and merges no flags.
- R12: A write to the rounding-mode register is visible on `frm_o` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid_i | input | 1 | An operation is presented for issue |
| insn_rm_i | input | 3 | Instruction rounding field (instruction bits 14:12) |
| dp_flags_i | input | 5 | Exception flags reported by the datapath at done |
| dp_done_i | input | 1 | Datapath completion pulse |
| frm_we_i | input | 1 | Rounding-mode register write enable |
| frm_wdata_i | input | 3 | Rounding-mode register write data |
| fflags_we_i | input | 1 | Flag register write enable |
| fflags_wdata_i | input | 5 | Flag register write data |
| rm_o | output | 3 | Effective rounding-mode code |
| fault_o | output | 1 | Illegal-instruction strobe |
| wb_en_o | output | 1 | Result writeback enable |
| frm_o | output | 3 | Rounding-mode register value |
| fflags_o | output | 5 | Sticky flag register value |

## Verification
The resolver is tried with every static code 0 to 4 and with the dynamic code over several register values. The reserved static codes 5 and 6, and the reserved register values 5, 6 and 7, must each raise the fault. Together these separate a decoder that maps each code correctly from one that mixes up static and dynamic sources or misses a reserved value. A register write during an in-flight dynamic operation, and a reserved issue while BUSY, show whether the mode is captured at issue and whether issue is properly gated by the sequencer. The flag patterns are single bits, an all-zero completion, a done pulse after a fault, and a same-cycle register write. These tell an OR merge apart from a plain overwrite, and show the write-over-merge priority.

// File: rtl/fpctl_pkg.sv
package fpctl_pkg;

    localparam int RM_W   = 3;
    localparam int FLAG_W = 5;

    // Rounding codes; 5 and 6 are reserved, 7 selects the dynamic register
    typedef enum logic [2:0] {
        RM_NEAR_EVEN = 3'd0,
        RM_TO_ZERO   = 3'd1,
        RM_DOWN      = 3'd2,
        RM_UP        = 3'd3,
        RM_NEAR_MAX  = 3'd4,
        RM_RSVD5     = 3'd5,
        RM_RSVD6     = 3'd6,
        RM_DYNAMIC   = 3'd7
    } rm_code_e;

    // Flag bit positions
    localparam int FLG_INEXACT   = 0;
    localparam int FLG_UNDERFLOW = 1;
    localparam int FLG_OVERFLOW  = 2;
    localparam int FLG_DIVZERO   = 3;
    localparam int FLG_INVALID   = 4;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } seq_state_e;

    function automatic logic rm_is_direct(input logic [RM_W-1:0] code);
        return (code <= RM_W'(RM_NEAR_MAX));
    endfunction

endpackage

// File: rtl/fpctl_rm_decode.sv
module fpctl_rm_decode
    import fpctl_pkg::*;
#(
    parameter int W = RM_W
) (
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] frm_i,
    output logic [W-1:0] mode_o,
    output logic         illegal_o
);

    logic         use_dyn;
    logic [W-1:0] src;

    always_comb begin
        use_dyn   = (field_i == W'(RM_DYNAMIC));
        src       = use_dyn ? frm_i : field_i;
        illegal_o = !rm_is_direct(src);
        mode_o    = illegal_o ? W'(RM_NEAR_EVEN) : src;
    end

endmodule

// File: rtl/fpctl_csr_field.sv
module fpctl_csr_field #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         merge_en_i,
    input  logic [W-1:0] merge_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q;

    // One cell per bit: write wins, otherwise OR-accumulate
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (we_i)
                q[i] <= wdata_i[i];
            else if (merge_en_i && merge_i[i])
                q[i] <= 1'b1;
        end
    end

    assign q_o = q;

    // R9: a write lands exactly, regardless of a same-cycle merge
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q_o == $past(wdata_i)));

    // R7: without a write, no bit ever falls
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/fpctl_seq.sv
module fpctl_seq
    import fpctl_pkg::*;
#(
    parameter int W = RM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_valid_i,
    input  logic [W-1:0] dec_mode_i,
    input  logic         dec_illegal_i,
    input  logic         dp_done_i,
    output logic [W-1:0] rm_o,
    output logic         fault_o,
    output logic         wb_en_o
);

    seq_state_e   st_q, st_d;
    logic [W-1:0] mode_q;
    logic         accept;

    // State register and captured mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            mode_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept)
                mode_q <= dec_mode_i;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (issue_valid_i && !dec_illegal_i) st_d = S_BUSY;
            S_BUSY: if (dp_done_i)                       st_d = S_IDLE;
            default:                                     st_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = 1'b0;
        fault_o = 1'b0;
        wb_en_o = 1'b0;
        rm_o    = dec_mode_i;
        unique case (st_q)
            S_IDLE: begin
                accept  = issue_valid_i && !dec_illegal_i;
                fault_o = issue_valid_i &&  dec_illegal_i;
            end
            S_BUSY: begin
                rm_o    = mode_q;
                wb_en_o = dp_done_i;
            end
            default: ;
        endcase
    end

    // R4/R5: a reserved issue in IDLE faults and never writes back
    p_reserved_faults_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_IDLE && issue_valid_i && dec_illegal_i) |-> (fault_o && !wb_en_o));

    // R10: no fault is raised while an operation is in flight
    p_fault_only_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (st_q == S_IDLE));

    // R6: the writeback enable is a single-cycle pulse
    p_wb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |=> !wb_en_o);

    // R3: mode is held while waiting for done
    p_mode_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_BUSY && !dp_done_i) |=> $stable(rm_o));

endmodule

// File: rtl/fprm_flag_ctrl.sv
module fprm_flag_ctrl
    import fpctl_pkg::*;
#(
    parameter int MODE_W = RM_W,
    parameter int FLG_W  = FLAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid_i,
    input  logic [MODE_W-1:0] insn_rm_i,
    input  logic [FLG_W-1:0]  dp_flags_i,
    input  logic              dp_done_i,
    input  logic              frm_we_i,
    input  logic [MODE_W-1:0] frm_wdata_i,
    input  logic              fflags_we_i,
    input  logic [FLG_W-1:0]  fflags_wdata_i,
    output logic [MODE_W-1:0] rm_o,
    output logic              fault_o,
    output logic              wb_en_o,
    output logic [MODE_W-1:0] frm_o,
    output logic [FLG_W-1:0]  fflags_o
);

    logic [MODE_W-1:0] dec_mode;
    logic              dec_illegal;

    fpctl_csr_field #(.W(MODE_W)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (frm_we_i),
        .wdata_i    (frm_wdata_i),
        .merge_en_i (1'b0),
        .merge_i    ('0),
        .q_o        (frm_o)
    );

    fpctl_rm_decode #(.W(MODE_W)) u_dec (
        .field_i   (insn_rm_i),
        .frm_i     (frm_o),
        .mode_o    (dec_mode),
        .illegal_o (dec_illegal)
    );

    fpctl_seq #(.W(MODE_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_valid_i (issue_valid_i),
        .dec_mode_i    (dec_mode),
        .dec_illegal_i (dec_illegal),
        .dp_done_i     (dp_done_i),
        .rm_o          (rm_o),
        .fault_o       (fault_o),
        .wb_en_o       (wb_en_o)
    );

    fpctl_csr_field #(.W(FLG_W)) u_fflags (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (fflags_we_i),
        .wdata_i    (fflags_wdata_i),
        .merge_en_i (wb_en_o),
        .merge_i    (dp_flags_i),
        .q_o        (fflags_o)
    );

    // R8: a faulting cycle leaves the flags alone
    p_fault_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !fflags_we_i) |=> (fflags_o == $past(fflags_o)));

    // R11: without writeback or write, flags hold
    p_idle_done_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wb_en_o && !fflags_we_i) |=> $stable(fflags_o));

endmodule

// File: tb/sim_fprm_flag_ctrl.sv
`timescale 1ns/1ps
module sim_fprm_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue_valid_i = 1'b0;
    logic [2:0] insn_rm_i = 3'd0;
    logic [4:0] dp_flags_i = 5'd0;
    logic       dp_done_i = 1'b0;
    logic       frm_we_i = 1'b0;
    logic [2:0] frm_wdata_i = 3'd0;
    logic       fflags_we_i = 1'b0;
    logic [4:0] fflags_wdata_i = 5'd0;
    logic [2:0] rm_o;
    logic       fault_o;
    logic       wb_en_o;
    logic [2:0] frm_o;
    logic [4:0] fflags_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;
    logic [4:0] exp_ff = 5'd0;

    always #2.5 clk = ~clk;

    fprm_flag_ctrl u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_frm(input logic [2:0] v);
        @(negedge clk); frm_we_i = 1'b1; frm_wdata_i = v;
        @(negedge clk); frm_we_i = 1'b0;
        #1 chk("R12 frm write", frm_o, v);
    endtask

    // Legal operation from issue to completion
    task automatic run_op(input logic [2:0] code, input logic [2:0] expm,
                          input logic [4:0] flg, input string req);
        @(negedge clk); issue_valid_i = 1'b1; insn_rm_i = code;
        #1 chk({req, " mode at issue"}, rm_o, expm);
        chk({req, " no fault"}, fault_o, 0);
        @(negedge clk); issue_valid_i = 1'b0; insn_rm_i = 3'd0;
        #1 chk({req, " mode held (R2)"}, rm_o, expm);
        chk("R6 no wb before done", wb_en_o, 0);
        dp_done_i = 1'b1; dp_flags_i = flg;
        #1 chk("R6 wb on done", wb_en_o, 1);
        @(negedge clk); dp_done_i = 1'b0; dp_flags_i = 5'd0;
        exp_ff = exp_ff | flg;
        #1 chk("R6 R7 flag merge", fflags_o, exp_ff);
        chk("R6 wb single cycle", wb_en_o, 0);
    endtask

    // Reserved issue, followed by a stray done carrying flags
    task automatic run_fault(input logic [2:0] code, input string req);
        @(negedge clk); issue_valid_i = 1'b1; insn_rm_i = code;
        #1 chk({req, " fault"}, fault_o, 1);
        chk({req, " no wb"}, wb_en_o, 0);
        @(negedge clk); issue_valid_i = 1'b0; insn_rm_i = 3'd0;
        #1 chk({req, " fault one cycle"}, fault_o, 0);
        dp_done_i = 1'b1; dp_flags_i = 5'h1f;
        #1 chk("R11 no wb in idle", wb_en_o, 0);
        @(negedge clk); dp_done_i = 1'b0; dp_flags_i = 5'd0;
        #1 chk("R8 R11 flags untouched", fflags_o, exp_ff);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 frm", frm_o, 0);
        chk("R1 fflags", fflags_o, 0);
        chk("R1 fault", fault_o, 0);
        chk("R1 wb", wb_en_o, 0);
        exp_ff = 5'd0;
    endtask

    task automatic t_static();
        run_op(3'd0, 3'd0, 5'b00001, "R2 nearest-even");
        run_op(3'd1, 3'd1, 5'b00010, "R2 toward-zero");
        run_op(3'd2, 3'd2, 5'b00100, "R2 down");
        run_op(3'd3, 3'd3, 5'b01000, "R2 up");
        run_op(3'd4, 3'd4, 5'b00000, "R2 R7 ties-max");
    endtask

    task automatic t_dynamic();
        write_frm(3'd2);
        @(negedge clk); issue_valid_i = 1'b1; insn_rm_i = 3'd7;
        #1 chk("R3 dynamic resolves frm", rm_o, 2);
        @(negedge clk); issue_valid_i = 1'b0; frm_we_i = 1'b1; frm_wdata_i = 3'd4;
        @(negedge clk); frm_we_i = 1'b0;
        #1 chk("R3 frm changed", frm_o, 4);
        chk("R3 in-flight mode kept", rm_o, 2);
        dp_done_i = 1'b1; dp_flags_i = 5'b10000;
        @(negedge clk); dp_done_i = 1'b0; dp_flags_i = 5'd0;
        exp_ff = exp_ff | 5'b10000;
        #1 chk("R6 invalid bit merged", fflags_o, exp_ff);
        run_op(3'd7, 3'd4, 5'b00000, "R3 dynamic ties-max");
    endtask

    task automatic t_faults();
        run_fault(3'd5, "R4 static 5");
        run_fault(3'd6, "R4 static 6");
        write_frm(3'd5); run_fault(3'd7, "R5 dyn frm 5");
        write_frm(3'd6); run_fault(3'd7, "R5 dyn frm 6");
        write_frm(3'd7); run_fault(3'd7, "R5 dyn frm 7");
        write_frm(3'd1);
    endtask

    task automatic t_busy_issue();
        @(negedge clk); issue_valid_i = 1'b1; insn_rm_i = 3'd3;
        @(negedge clk); insn_rm_i = 3'd5;
        #1 chk("R10 no fault while busy", fault_o, 0);
        chk("R10 mode kept", rm_o, 3);
        @(negedge clk); issue_valid_i = 1'b0;
        dp_done_i = 1'b1; dp_flags_i = 5'd0;
        #1 chk("R10 wb for first op", wb_en_o, 1);
        @(negedge clk); dp_done_i = 1'b0;
        #1 chk("R10 back idle", wb_en_o, 0);
    endtask

    task automatic t_priority();
        @(negedge clk); issue_valid_i = 1'b1; insn_rm_i = 3'd0;
        @(negedge clk); issue_valid_i = 1'b0;
        dp_done_i = 1'b1; dp_flags_i = 5'b10000;
        fflags_we_i = 1'b1; fflags_wdata_i = 5'b00010;
        @(negedge clk); dp_done_i = 1'b0; dp_flags_i = 5'd0; fflags_we_i = 1'b0;
        exp_ff = 5'b00010;
        #1 chk("R9 write beats merge", fflags_o, exp_ff);
        run_op(3'd0, 3'd0, 5'b00000, "R7 zero-flag done");
        chk("R7 sticky bit kept", fflags_o, 5'b00010);
    endtask

    initial begin
        t_reset();
        t_static();
        t_dynamic();
        t_faults();
        t_busy_issue();
        t_priority();
        repeat (2) @(negedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done_flag) begin
            done_flag = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule